// File: doc/BRIEF.md
# Nested Hardware Loop Sequencer

This block runs nested zero-overhead loops next to a fetch unit with a 16-bit program counter. A loop-start command carries the address of the loop's last instruction, an iteration count, the current program counter (the first instruction of the loop body) and the status word. The sequencer first saves the active loop's end address and count as one stack entry. It then saves the program counter and status as a second entry. Only after that does it load the new end address and count and raise the loop flag.

While the flag is up, every valid fetch address is compared with the loop-end register. On a match with a count above one, the count drops by one and the fetch is redirected in the same cycle to the program-counter half of the stack top. On a match with a count of one, fetch continues in sequence and the sequencer unstacks. It pulls the context entry, of which only the loop-flag bit is kept, then pulls the loop entry back into the end-address and count registers. An early-exit command performs the same unstacking.

Stack storage lives outside the block. It is reached through a push stream and a pull stream, each with valid/ready handshakes. The valid side holds its request, with the data unchanged, until ready is seen. Pull data must be valid in the cycle of the pull handshake. The stack-top program-counter field must show the current top at all times. `busy_o` is high while a push or pull sequence is in flight. The fetch unit is expected to stall on it.

Top module: `hw_loop_seq`

## Requirements
- R1: After reset the loop flag, loop-end address, loop count and busy are all zero, and neither push nor pull is requested.
- R2: An accepted start pushes {loop-end address[31:16], count[15:0]} and then {start PC[31:16], status[15:0]}. After the second push handshake it loads the commanded end address and count and sets the loop flag. With ready held high, this takes two cycles.
- R3: When idle with the flag set, a valid fetch equal to the loop-end address with a count other than one raises `redirect_o` in that same cycle. `redirect_pc_o` equals the stack-top program counter, and the count is one lower in the next cycle.
- R4: The same match with a count of one gives no redirect and starts unstacking. The first pull sets the flag from bit 15 of the entry, and all other status bits are dropped. The second pull restores the end address from bits 31:16 and the count from bits 15:0.
- R5: An exit command while idle with the flag set performs the R4 unstacking. If it coincides with a loop-end match, the exit wins: there is no redirect and no decrement, and only one unstack (two pulls) takes place.
- R6: A start count of zero runs as 65536 iterations: the first loop-end match leaves a count of 16'hFFFF.
- R7: The current loop count is visible on `loop_cnt_o` in every cycle, including mid-loop.
- R8: While a handshake is pending, valid stays high with stable data and `busy_o` stays high. Start, exit and fetch matches are ignored while busy.
- R9: A start that arrives together with an accepted exit or terminating match is ignored. A fetch match and an exit are both ignored while the flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Loop-start command |
| start_pc_i | input | 16 | First address of the loop body |
| start_sr_i | input | 16 | Status word to save; bit 15 is the loop flag |
| start_la_i | input | 16 | Address of the last loop instruction |
| start_cnt_i | input | 16 | Iteration count (0 means 65536) |
| exit_i | input | 1 | Early-exit command |
| fetch_valid_i | input | 1 | Fetch address is valid |
| fetch_addr_i | input | 16 | Current fetch address |
| redirect_o | output | 1 | Take the next fetch from redirect_pc_o |
| redirect_pc_o | output | 16 | Loop-body start address |
| push_valid_o | output | 1 | Push request |
| push_ready_i | input | 1 | Stack accepts push |
| push_data_o | output | 32 | Entry to push |
| pull_valid_o | output | 1 | Pull request |
| pull_ready_i | input | 1 | Stack completes pull |
| pull_data_i | input | 32 | Top entry being pulled |
| top_pc_i | input | 16 | Program-counter half of the stack top |
| loop_flag_o | output | 1 | A hardware loop is active |
| loop_addr_o | output | 16 | Loop-end address register |
| loop_cnt_o | output | 16 | Loop count register |
| busy_o | output | 1 | Push or pull sequence in progress |

## Verification
Two things can land in the same idle cycle: an early exit and a loop-end fetch match. They can collide both while the count is above one and while it equals one. The bench drives both in one cycle and expects no redirect, an unchanged count and exactly two pulls. It also pairs a start with an exit, and there it expects the stack depth to fall by two with nothing pushed. Every such cycle, plus stalled handshakes that stretch the push and pull phases, is judged against a behavioural model and a queue-based stack that are compared on every clock.

// File: rtl/hwl_pkg.sv
package hwl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH_LOOP,
    ST_PUSH_CTX,
    ST_PULL_CTX,
    ST_PULL_LOOP
  } hwl_state_e;
endpackage

// File: rtl/hwl_end_detect.sv
// Decides, for an idle cycle, whether the loop iterates or unstacks.
module hwl_end_detect #(
  parameter int W = 16
) (
  input  logic         idle_i,
  input  logic         flag_i,
  input  logic         exit_i,
  input  logic         fetch_valid_i,
  input  logic [W-1:0] fetch_addr_i,
  input  logic [W-1:0] loop_addr_i,
  input  logic [W-1:0] loop_cnt_i,
  output logic         iterate_o,
  output logic         unstack_o
);
  localparam logic [W-1:0] LAST_CNT = W'(1);

  logic hit;
  logic last;

  always_comb begin
    hit       = idle_i && flag_i && fetch_valid_i && (fetch_addr_i == loop_addr_i);
    last      = (loop_cnt_i == LAST_CNT);
    unstack_o = idle_i && flag_i && (exit_i || (hit && last));
    iterate_o = hit && !last && !exit_i;
  end
endmodule

// File: rtl/hwl_ctrl.sv
// Sequencing FSM and loop registers.
module hwl_ctrl
  import hwl_pkg::*;
#(
  parameter int W      = 16,
  parameter int LF_BIT = 15
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic [W-1:0]   start_pc_i,
  input  logic [W-1:0]   start_sr_i,
  input  logic [W-1:0]   start_la_i,
  input  logic [W-1:0]   start_cnt_i,
  input  logic           iterate_i,
  input  logic           unstack_i,
  output logic           push_valid_o,
  input  logic           push_ready_i,
  output logic [2*W-1:0] push_data_o,
  output logic           pull_valid_o,
  input  logic           pull_ready_i,
  input  logic [2*W-1:0] pull_data_i,
  output logic           loop_flag_o,
  output logic [W-1:0]   loop_addr_o,
  output logic [W-1:0]   loop_cnt_o,
  output logic           busy_o
);
  localparam int EW = 2 * W;

  hwl_state_e st;
  logic         flag;
  logic [W-1:0] la;
  logic [W-1:0] lc;
  logic [W-1:0] sv_pc;
  logic [W-1:0] sv_sr;
  logic [W-1:0] sv_la;
  logic [W-1:0] sv_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      flag   <= 1'b0;
      la     <= '0;
      lc     <= '0;
      sv_pc  <= '0;
      sv_sr  <= '0;
      sv_la  <= '0;
      sv_cnt <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (unstack_i) begin
            st <= ST_PULL_CTX;
          end else if (iterate_i) begin
            lc <= lc - 1'b1;
          end else if (start_i) begin
            sv_pc  <= start_pc_i;
            sv_sr  <= start_sr_i;
            sv_la  <= start_la_i;
            sv_cnt <= start_cnt_i;
            st     <= ST_PUSH_LOOP;
          end
        end
        ST_PUSH_LOOP: if (push_ready_i) st <= ST_PUSH_CTX;
        ST_PUSH_CTX: if (push_ready_i) begin
          la   <= sv_la;
          lc   <= sv_cnt;
          flag <= 1'b1;
          st   <= ST_IDLE;
        end
        ST_PULL_CTX: if (pull_ready_i) begin
          flag <= pull_data_i[LF_BIT];
          st   <= ST_PULL_LOOP;
        end
        ST_PULL_LOOP: if (pull_ready_i) begin
          la <= pull_data_i[EW-1:W];
          lc <= pull_data_i[W-1:0];
          st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    push_valid_o = (st == ST_PUSH_LOOP) || (st == ST_PUSH_CTX);
    pull_valid_o = (st == ST_PULL_CTX) || (st == ST_PULL_LOOP);
    push_data_o  = (st == ST_PUSH_LOOP) ? {la, lc} : {sv_pc, sv_sr};
    busy_o       = (st != ST_IDLE);
    loop_flag_o  = flag;
    loop_addr_o  = la;
    loop_cnt_o   = lc;
  end
endmodule

// File: rtl/hw_loop_seq.sv
module hw_loop_seq #(
  parameter int W      = 16,
  parameter int LF_BIT = 15
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic [W-1:0]   start_pc_i,
  input  logic [W-1:0]   start_sr_i,
  input  logic [W-1:0]   start_la_i,
  input  logic [W-1:0]   start_cnt_i,
  input  logic           exit_i,
  input  logic           fetch_valid_i,
  input  logic [W-1:0]   fetch_addr_i,
  output logic           redirect_o,
  output logic [W-1:0]   redirect_pc_o,
  output logic           push_valid_o,
  input  logic           push_ready_i,
  output logic [2*W-1:0] push_data_o,
  output logic           pull_valid_o,
  input  logic           pull_ready_i,
  input  logic [2*W-1:0] pull_data_i,
  input  logic [W-1:0]   top_pc_i,
  output logic           loop_flag_o,
  output logic [W-1:0]   loop_addr_o,
  output logic [W-1:0]   loop_cnt_o,
  output logic           busy_o
);
  logic iterate;
  logic unstack;

  hwl_end_detect #(.W(W)) u_det (
    .idle_i        (!busy_o),
    .flag_i        (loop_flag_o),
    .exit_i        (exit_i),
    .fetch_valid_i (fetch_valid_i),
    .fetch_addr_i  (fetch_addr_i),
    .loop_addr_i   (loop_addr_o),
    .loop_cnt_i    (loop_cnt_o),
    .iterate_o     (iterate),
    .unstack_o     (unstack)
  );

  hwl_ctrl #(.W(W), .LF_BIT(LF_BIT)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .start_pc_i   (start_pc_i),
    .start_sr_i   (start_sr_i),
    .start_la_i   (start_la_i),
    .start_cnt_i  (start_cnt_i),
    .iterate_i    (iterate),
    .unstack_i    (unstack),
    .push_valid_o (push_valid_o),
    .push_ready_i (push_ready_i),
    .push_data_o  (push_data_o),
    .pull_valid_o (pull_valid_o),
    .pull_ready_i (pull_ready_i),
    .pull_data_i  (pull_data_i),
    .loop_flag_o  (loop_flag_o),
    .loop_addr_o  (loop_addr_o),
    .loop_cnt_o   (loop_cnt_o),
    .busy_o       (busy_o)
  );

  assign redirect_o    = iterate;
  assign redirect_pc_o = top_pc_i;
endmodule

// File: rtl/hwl_checker.sv
module hwl_checker #(
  parameter int W = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           redirect_o,
  input logic           push_valid_o,
  input logic           push_ready_i,
  input logic [2*W-1:0] push_data_o,
  input logic           pull_valid_o,
  input logic           pull_ready_i,
  input logic           loop_flag_o,
  input logic [W-1:0]   loop_cnt_o,
  input logic           busy_o
);
  AST_PUSH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid_o && !push_ready_i |=> push_valid_o && $stable(push_data_o)); // R8
  AST_PULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    pull_valid_o && !pull_ready_i |=> pull_valid_o); // R8
  AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
    !(push_valid_o && pull_valid_o)); // R2
  AST_REDIRECT_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |-> loop_flag_o && !busy_o); // R3
  AST_REDIRECT_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |=> loop_cnt_o == W'($past(loop_cnt_o) - 1'b1)); // R3
  AST_BUSY_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (push_valid_o || pull_valid_o)); // R8
endmodule

bind hw_loop_seq hwl_checker #(.W(W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .redirect_o   (redirect_o),
  .push_valid_o (push_valid_o),
  .push_ready_i (push_ready_i),
  .push_data_o  (push_data_o),
  .pull_valid_o (pull_valid_o),
  .pull_ready_i (pull_ready_i),
  .loop_flag_o  (loop_flag_o),
  .loop_cnt_o   (loop_cnt_o),
  .busy_o       (busy_o)
);

// File: tb/tb_hw_loop_seq.sv
`timescale 1ns/1ps
module tb_hw_loop_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 0, exit_i = 0, fetch_valid_i = 0;
  logic [15:0] start_pc_i = 0, start_sr_i = 0, start_la_i = 0, start_cnt_i = 0;
  logic [15:0] fetch_addr_i = 0, top_pc_i = 0;
  logic        push_ready_i = 1, pull_ready_i = 1;
  logic [31:0] pull_data_i = 0;
  logic        redirect_o, push_valid_o, pull_valid_o, loop_flag_o, busy_o;
  logic [15:0] redirect_pc_o, loop_addr_o, loop_cnt_o;
  logic [31:0] push_data_o;

  always #4 clk = ~clk;

  hw_loop_seq dut (.*);

  int ncheck = 0;
  int nerr = 0;
  int cyc = 0;
  bit done = 0;

  // stimulus globals
  bit        g_start, g_exit, g_fv, g_stall;
  logic [15:0] g_pc, g_sr, g_la, g_cnt, g_fa;

  // environment stack
  logic [31:0] stk[$];

  // reference model
  int          m_st;
  bit          m_lf;
  logic [15:0] m_la, m_lc, s_pc, s_sr, s_la, s_cnt;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    ncheck++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic step();
    logic [31:0] top;
    bit pr, lr, e_redir, hit;
    @(negedge clk);
    chk("R4 loop flag", loop_flag_o, m_lf);
    chk("R2 loop addr", loop_addr_o, m_la);
    chk("R7 loop count", loop_cnt_o, m_lc);
    chk("R8 busy", busy_o, m_st != 0);
    pr = g_stall ? (cyc % 3 == 2) : 1'b1;
    lr = g_stall ? (cyc % 3 == 1) : 1'b1;
    top = (stk.size() > 0) ? stk[stk.size()-1] : 32'h0;
    start_i = g_start; exit_i = g_exit; fetch_valid_i = g_fv; fetch_addr_i = g_fa;
    start_pc_i = g_pc; start_sr_i = g_sr; start_la_i = g_la; start_cnt_i = g_cnt;
    push_ready_i = pr; pull_ready_i = lr;
    pull_data_i = top; top_pc_i = top[31:16];
    #1;
    hit = (m_st == 0) && m_lf && g_fv && (g_fa == m_la);
    e_redir = hit && (m_lc != 16'd1) && !g_exit;
    chk("R3 redirect", redirect_o, e_redir);
    if (e_redir) chk("R3 redirect pc", redirect_pc_o, top[31:16]);
    chk("R2 push valid", push_valid_o, (m_st == 1) || (m_st == 2));
    if (m_st == 1) chk("R2 push loop entry", push_data_o, {m_la, m_lc});
    if (m_st == 2) chk("R2 push ctx entry", push_data_o, {s_pc, s_sr});
    chk("R4 pull valid", pull_valid_o, (m_st == 3) || (m_st == 4));
    @(posedge clk);
    cyc++;
    case (m_st)
      0: begin
        if (m_lf && (g_exit || (hit && m_lc == 16'd1))) m_st = 3;
        else if (e_redir) m_lc = m_lc - 16'd1;
        else if (g_start) begin
          s_pc = g_pc; s_sr = g_sr; s_la = g_la; s_cnt = g_cnt; m_st = 1;
        end
      end
      1: if (pr) begin stk.push_back({m_la, m_lc}); m_st = 2; end
      2: if (pr) begin
        stk.push_back({s_pc, s_sr}); m_la = s_la; m_lc = s_cnt; m_lf = 1; m_st = 0;
      end
      3: if (lr) begin m_lf = top[15]; void'(stk.pop_back()); m_st = 4; end
      4: if (lr) begin m_la = top[31:16]; m_lc = top[15:0]; void'(stk.pop_back()); m_st = 0; end
      default: m_st = 0;
    endcase
    g_start = 0; g_exit = 0; g_fv = 0;
  endtask

  task automatic settle();
    while (m_st != 0) step();
  endtask

  task automatic do_start(logic [15:0] la, logic [15:0] cnt, logic [15:0] pc, logic [15:0] sr);
    g_start = 1; g_la = la; g_cnt = cnt; g_pc = pc; g_sr = sr;
    step();
    settle();
  endtask

  task automatic fetch(logic [15:0] a);
    g_fv = 1; g_fa = a;
    step();
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      ncheck++; nerr++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", ncheck, nerr);
      $finish;
    end
  end

  initial begin
    int depth;
    m_st = 0; m_lf = 0; m_la = 0; m_lc = 0;
    s_pc = 0; s_sr = 0; s_la = 0; s_cnt = 0;
    g_start = 0; g_exit = 0; g_fv = 0; g_stall = 0;
    g_pc = 0; g_sr = 0; g_la = 0; g_cnt = 0; g_fa = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset flag", loop_flag_o, 0);
    chk("R1 reset busy", busy_o, 0);
    chk("R1 reset count", loop_cnt_o, 0);
    chk("R1 reset push", push_valid_o, 0);
    rst_n = 1;
    step(); step();

    // single loop of three iterations
    do_start(16'h0010, 16'd3, 16'h0008, 16'h0300);
    chk("R2 stack depth after start", stk.size(), 2);
    fetch(16'h0009);
    fetch(16'h0010);
    fetch(16'h000C);
    fetch(16'h0010);
    #1 chk("R7 count mid loop", loop_cnt_o, 1);
    fetch(16'h0010);
    settle();
    #1 chk("R4 flag restored clear", loop_flag_o, 0);
    chk("R4 stack empty", stk.size(), 0);

    // ignored while flag clear (R9)
    fetch(16'h0000);
    g_exit = 1; step();
    #1 chk("R9 exit ignored", busy_o, 0);
    chk("R9 exit no pull", stk.size(), 0);

    // nested loops, zero count, early exit
    do_start(16'h0040, 16'd2, 16'h0020, 16'h0000);
    do_start(16'h0030, 16'd0, 16'h0028, 16'h8000);
    chk("R2 nested depth", stk.size(), 4);
    fetch(16'h0030);
    #1 chk("R6 zero count wraps", loop_cnt_o, 16'hFFFF);
    fetch(16'h0030);
    g_exit = 1; step();
    settle();
    #1 chk("R5 exit restores addr", loop_addr_o, 16'h0040);
    chk("R5 exit restores count", loop_cnt_o, 2);
    chk("R5 exit restores flag", loop_flag_o, 1);
    // exit colliding with iterating match
    g_exit = 1; g_fv = 1; g_fa = 16'h0040; step();
    settle();
    #1 chk("R5 collision single unstack", stk.size(), 0);
    chk("R5 collision flag", loop_flag_o, 0);

    // back-pressure and ignored commands while busy
    g_stall = 1;
    g_start = 1; g_la = 16'h0100; g_cnt = 16'd4; g_pc = 16'h00F0; g_sr = 16'h0001;
    step();
    g_start = 1; g_la = 16'h0200; g_cnt = 16'd9; step();
    g_exit = 1; step();
    settle();
    #1 chk("R8 busy start ignored", loop_addr_o, 16'h0100);
    chk("R8 stall depth", stk.size(), 2);
    fetch(16'h0100);
    fetch(16'h0100);
    // start together with exit: start dropped (R9)
    depth = stk.size();
    g_exit = 1; g_start = 1; g_la = 16'h0300; g_cnt = 16'd5; step();
    settle();
    #1 chk("R9 start with exit dropped", stk.size(), depth - 2);
    chk("R9 addr after drop", loop_addr_o, 16'h0000);
    g_stall = 0;

    // terminating match together with exit at count one
    do_start(16'h0050, 16'd1, 16'h0044, 16'h0000);
    g_exit = 1; g_fv = 1; g_fa = 16'h0050; step();
    settle();
    #1 chk("R5 end plus exit one unstack", stk.size(), 0);
    repeat (3) step();

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", ncheck, nerr);
    $finish;
  end
endmodule